// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Word Formatting

This block sits between a bus and the serial side of a digital audio interface. It holds two sample queues. On the transmit side, bus writes place 32-bit words into a transmit queue. Each word is aligned into a 24-bit sample on entry, and a serializer then pops the samples. On the receive side, a deserializer pushes 24-bit samples into a receive queue. The bus reads them back as 32-bit words, packed in one of four ways chosen by a control field.

A single control word sets the block up. It holds a path enable, the two queue thresholds, the transmit alignment and the receive packing mode, plus two self-clearing flush bits. Each queue raises a request line for interrupt or DMA service when its fill state crosses its threshold. A write to a full transmit queue, a pop from an empty transmit queue, a push into a full receive queue and a read from an empty receive queue are each dropped. Each such drop sets its own sticky flag, and the flag clears when that queue is flushed.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the control word reads 0x00001078. Its fields are: bit 31 path enable, bit 17 transmit flush, bit 16 receive flush, bits 12:8 transmit threshold, bits 7:3 receive threshold, bit 2 transmit alignment, bits 1:0 receive packing. After reset both queues are empty and all four sticky flags are low.
- R2: With transmit alignment 0, a bus write stores write-data bits 31:8 as the 24-bit sample.
- R3: With transmit alignment 1, a bus write stores write-data bits 19:0 as sample bits 23:4, with sample bits 3:0 zero.
- R4: The receive read word is formed from the oldest sample s according to the packing field. Code 0 gives {s, 8 zeros}. Code 1 gives s with s[23] copied into bits 31:24. Code 2 gives {s[23:8], 16 zeros}. Code 3 gives s[23:8] in bits 15:0 with s[23] copied into bits 31:16.
- R5: Each queue holds 32 samples in first-in first-out order. A bus write to a full transmit queue is dropped and sets the transmit overflow flag. A serializer pop from an empty transmit queue sets the transmit underflow flag.
- R6: A bus read from an empty receive queue is dropped and sets the receive underflow flag. A deserializer push into a full receive queue is dropped and sets the receive overflow flag.
- R7: The transmit request is high exactly when the free space (32 minus the stored count) is at least the transmit threshold field.
- R8: The receive request is high exactly when the stored count is at least the receive threshold field plus one.
- R9: A control write with a flush bit set leaves that queue empty at the next clock edge, even if a push or pop is attempted in the same cycle, and clears that queue's two sticky flags. The flush bits always read back 0.
- R10: While the path enable is 0, serializer pops and deserializer pushes are ignored: no sample moves and no flag is set. Bus writes and reads still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| tx_wr | input | 1 | Bus write into the transmit queue |
| tx_wdata | input | 32 | Bus write word |
| tx_full | output | 1 | Transmit queue full |
| tx_count | output | 6 | Transmit queue fill count |
| ser_pop | input | 1 | Serializer takes one sample |
| ser_data | output | 24 | Oldest transmit sample |
| ser_valid | output | 1 | Transmit queue not empty |
| des_push | input | 1 | Deserializer delivers one sample |
| des_data | input | 24 | Deserialized sample |
| rx_rd | input | 1 | Bus read from the receive queue |
| rx_rdata | output | 32 | Packed oldest receive sample |
| rx_empty | output | 1 | Receive queue empty |
| rx_count | output | 6 | Receive queue fill count |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
A flush can land in the same cycle as a push or pop on the queue it empties. The bench provokes this by issuing a transmit flush together with a bus write, both to a partly filled queue and to a full one. It also issues a receive flush together with a deserializer push and a bus read. In each case the queue must be empty one cycle later with its sticky flags low, so the flush wins and the dropped write leaves no overflow behind. The threshold sweeps also compare both request lines after every single push across all 33 fill levels.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;

  localparam int unsigned BUS_W    = 32;
  localparam int unsigned SMP_W    = 24;
  localparam int unsigned THR_W    = 5;

  // control word bit positions (software decodes these)
  localparam int unsigned BIT_HUB  = 31;
  localparam int unsigned BIT_TXFL = 17;
  localparam int unsigned BIT_RXFL = 16;
  localparam int unsigned TXT_LO   = 8;
  localparam int unsigned RXT_LO   = 3;
  localparam int unsigned BIT_TXAL = 2;

  typedef enum logic [1:0] {
    PK_PAD_LOW  = 2'd0,
    PK_SIGN_TOP = 2'd1,
    PK_HALF_HI  = 2'd2,
    PK_HALF_LO  = 2'd3
  } rx_pack_e;

  typedef struct packed {
    logic             path_en;
    logic [THR_W-1:0] tx_thr;
    logic [THR_W-1:0] rx_thr;
    logic             tx_lsb;
    rx_pack_e         rx_pack;
  } audfifo_cfg_t;

  // place a bus word into a sample; lsb_bits is the LSB-aligned width
  function automatic logic [SMP_W-1:0] align_tx(input logic lsb,
                                                input logic [BUS_W-1:0] w,
                                                input int unsigned lsb_bits);
    logic [BUS_W-1:0] mask;
    logic [BUS_W-1:0] tmp;
    mask = (BUS_W'(1) << lsb_bits) - BUS_W'(1);
    tmp  = (w & mask) << (SMP_W - lsb_bits);
    if (lsb) return tmp[SMP_W-1:0];
    return w[BUS_W-1 -: SMP_W];
  endfunction

  function automatic logic [BUS_W-1:0] pack_rx(input rx_pack_e m,
                                               input logic [SMP_W-1:0] s);
    logic [BUS_W-1:0] r;
    case (m)
      PK_PAD_LOW:  r = {s, {(BUS_W-SMP_W){1'b0}}};
      PK_SIGN_TOP: r = {{(BUS_W-SMP_W){s[SMP_W-1]}}, s};
      PK_HALF_HI:  r = {s[SMP_W-1 -: 16], 16'h0000};
      default:     r = {{16{s[SMP_W-1]}}, s[SMP_W-1 -: 16]};
    endcase
    return r;
  endfunction

  // free space at or above threshold
  function automatic logic free_reached(input int unsigned depth,
                                        input int unsigned count,
                                        input logic [THR_W-1:0] thr);
    return (depth - count) >= int'(thr);
  endfunction

  // stored entries at or above threshold plus one
  function automatic logic fill_reached(input int unsigned count,
                                        input logic [THR_W-1:0] thr);
    return count >= (int'(thr) + 1);
  endfunction

endpackage

// File: rtl/audfifo_ctrl.sv
module audfifo_ctrl
  import audfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output audfifo_cfg_t     cfg,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic [BUS_W-1:0] rdata
);

  localparam logic [THR_W-1:0] TX_THR_RST = THR_W'(16);
  localparam logic [THR_W-1:0] RX_THR_RST = THR_W'(15);

  audfifo_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.path_en <= 1'b0;
      cfg_q.tx_thr  <= TX_THR_RST;
      cfg_q.rx_thr  <= RX_THR_RST;
      cfg_q.tx_lsb  <= 1'b0;
      cfg_q.rx_pack <= PK_PAD_LOW;
    end else if (wr) begin
      cfg_q.path_en <= wdata[BIT_HUB];
      cfg_q.tx_thr  <= wdata[TXT_LO +: THR_W];
      cfg_q.rx_thr  <= wdata[RXT_LO +: THR_W];
      cfg_q.tx_lsb  <= wdata[BIT_TXAL];
      cfg_q.rx_pack <= rx_pack_e'(wdata[1:0]);
    end
  end

  // flush strobes are never stored, so they read back zero
  assign tx_flush = wr & wdata[BIT_TXFL];
  assign rx_flush = wr & wdata[BIT_RXFL];
  assign cfg      = cfg_q;

  always_comb begin
    rdata                     = '0;
    rdata[BIT_HUB]            = cfg_q.path_en;
    rdata[TXT_LO +: THR_W]    = cfg_q.tx_thr;
    rdata[RXT_LO +: THR_W]    = cfg_q.rx_thr;
    rdata[BIT_TXAL]           = cfg_q.tx_lsb;
    rdata[1:0]                = cfg_q.rx_pack;
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wdata[30:18], wdata[15:13]};

endmodule

// File: rtl/audfifo_queue.sv
module audfifo_queue #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             ovf_flag,
  output logic             udf_flag
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok, push_drop, pop_drop;

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign push_ok   = push & ~full  & ~flush;
  assign pop_ok    = pop  & ~empty & ~flush;
  assign push_drop = push &  full  & ~flush;
  assign pop_drop  = pop  &  empty & ~flush;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else if (flush) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (push_drop) ovf_flag <= 1'b1;
      if (pop_drop)  udf_flag <= 1'b1;
    end
  end

  assign head  = empty ? '0 : mem[rptr];
  assign count = cnt;

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import audfifo_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned LSB_BITS = 20,
  localparam int unsigned CW      = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              tx_wr,
  input  logic [31:0]       tx_wdata,
  output logic              tx_full,
  output logic [CW-1:0]     tx_count,
  input  logic              ser_pop,
  output logic [23:0]       ser_data,
  output logic              ser_valid,
  input  logic              des_push,
  input  logic [23:0]       des_data,
  input  logic              rx_rd,
  output logic [31:0]       rx_rdata,
  output logic              rx_empty,
  output logic [CW-1:0]     rx_count,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_ovf,
  output logic              tx_udf,
  output logic              rx_ovf,
  output logic              rx_udf
);

  audfifo_cfg_t cfg;
  logic         tx_flush, rx_flush;
  logic         path_en;
  logic         ser_take, des_give;
  logic [23:0]  tx_sample, rx_head;
  logic         tx_empty, rx_full;

  audfifo_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .rdata    (cfg_rdata)
  );

  assign path_en   = cfg.path_en;
  assign ser_take  = ser_pop  & path_en;
  assign des_give  = des_push & path_en;
  assign tx_sample = align_tx(cfg.tx_lsb, tx_wdata, LSB_BITS);

  audfifo_queue #(.WIDTH(SMP_W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (tx_wr),
    .push_data (tx_sample),
    .pop       (ser_take),
    .head      (ser_data),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty),
    .ovf_flag  (tx_ovf),
    .udf_flag  (tx_udf)
  );

  audfifo_queue #(.WIDTH(SMP_W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (des_give),
    .push_data (des_data),
    .pop       (rx_rd),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty),
    .ovf_flag  (rx_ovf),
    .udf_flag  (rx_udf)
  );

  logic unused_rx_full;
  assign unused_rx_full = rx_full;

  assign ser_valid = ~tx_empty;
  assign rx_rdata  = pack_rx(cfg.rx_pack, rx_head);
  assign tx_req    = free_reached(DEPTH, int'(tx_count), cfg.tx_thr);
  assign rx_req    = fill_reached(int'(rx_count), cfg.rx_thr);

endmodule

// File: rtl/audfifo_chk.sv
module audfifo_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          path_en,
  input logic          tx_wr,
  input logic          tx_full,
  input logic          tx_ovf,
  input logic          rx_rd,
  input logic          rx_empty,
  input logic          rx_udf,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);

  // R9: transmit flush leaves the queue empty
  a_r9_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_count == '0));

  // R9: receive flush leaves the queue empty
  a_r9_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_count == '0));

  // R5: write into a full queue raises the overflow flag
  a_r5_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full && !tx_flush) |=> tx_ovf);

  // R5: count never exceeds depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  // R6: read of an empty receive queue raises underflow
  a_r6_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty && !rx_flush) |=> rx_udf);

  // R10: with the path disabled and no bus read, receive count holds
  a_r10_path_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_en && !rx_rd && !rx_flush) |=> $stable(rx_count));

endmodule

bind audio_sample_fifo audfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_flush (tx_flush),
  .rx_flush (rx_flush),
  .path_en  (path_en),
  .tx_wr    (tx_wr),
  .tx_full  (tx_full),
  .tx_ovf   (tx_ovf),
  .rx_rd    (rx_rd),
  .rx_empty (rx_empty),
  .rx_udf   (rx_udf),
  .tx_count (tx_count),
  .rx_count (rx_count)
);

// File: tb/audio_sample_fifo_test.sv
`timescale 1ns/1ps
module audio_sample_fifo_test;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tx_wr = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_full;
  logic [5:0]  tx_count;
  logic        ser_pop = 1'b0;
  logic [23:0] ser_data;
  logic        ser_valid;
  logic        des_push = 1'b0;
  logic [23:0] des_data = '0;
  logic        rx_rd = 1'b0;
  logic [31:0] rx_rdata;
  logic        rx_empty;
  logic [5:0]  rx_count;
  logic        tx_req, rx_req, tx_ovf, tx_udf, rx_ovf, rx_udf;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  audio_sample_fifo uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .tx_full(tx_full), .tx_count(tx_count), .ser_pop(ser_pop),
    .ser_data(ser_data), .ser_valid(ser_valid), .des_push(des_push),
    .des_data(des_data), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .rx_empty(rx_empty), .rx_count(rx_count), .tx_req(tx_req),
    .rx_req(rx_req), .tx_ovf(tx_ovf), .tx_udf(tx_udf), .rx_ovf(rx_ovf),
    .rx_udf(rx_udf)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] cword(input logic en, input logic ftx, input logic frx,
                                        input int tthr, input int rthr,
                                        input logic tal, input int rpk);
    logic [31:0] v;
    v = 0;
    v[31] = en; v[17] = ftx; v[16] = frx;
    v[12:8] = 5'(tthr); v[7:3] = 5'(rthr); v[2] = tal; v[1:0] = 2'(rpk);
    return v;
  endfunction

  task automatic set_cfg(input logic [31:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; cyc(); cfg_wr = 1'b0;
  endtask

  function automatic logic [23:0] exp_tx(input logic lsb, input logic [31:0] w);
    if (lsb) return 24'((w % 32'h0010_0000) * 16);
    return 24'(w / 256);
  endfunction

  function automatic logic [31:0] exp_rx(input int m, input logic [23:0] s);
    logic signed [31:0] sx;
    sx = 32'(signed'(s));
    case (m)
      0: return {s, 8'h00};
      1: return sx;
      2: return (32'(s) / 256) * 65536;
      default: return sx >>> 8;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] words [33];
    logic [23:0] smps [33];
    int thr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 cfg reset", cfg_rdata, 32'h0000_1078);
    chk("R1 tx count", 32'(tx_count), 0);
    chk("R1 rx count", 32'(rx_count), 0);
    chk("R1 flags", {28'h0, tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
    chk("R7 reset tx_req", 32'(tx_req), 1);
    chk("R8 reset rx_req", 32'(rx_req), 0);

    // R10 path disabled: serial side ignored
    des_push = 1'b1; des_data = 24'h123456; cyc(); des_push = 1'b0;
    chk("R10 no rx push", 32'(rx_count), 0);
    ser_pop = 1'b1; cyc(); ser_pop = 1'b0;
    chk("R10 no tx udf", 32'(tx_udf), 0);
    tx_wr = 1'b1; tx_wdata = 32'hAABB_CCDD; cyc(); tx_wr = 1'b0;
    chk("R10 bus write acts", 32'(tx_count), 1);
    ser_pop = 1'b1; cyc(); ser_pop = 1'b0;
    chk("R10 serializer pop held", 32'(tx_count), 1);
    set_cfg(cword(1'b0, 1'b1, 1'b1, 16, 15, 1'b0, 0));

    // transmit sweeps over alignment and threshold
    for (int k = 0; k < 4; k++) begin
      logic lsb;
      lsb = k[0];
      thr = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 16 : 31;
      set_cfg(cword(1'b1, 1'b0, 1'b0, thr, 15, lsb, 0));
      chk("R7 tx_req empty", 32'(tx_req), 32'((DEPTH) >= thr));
      for (int i = 0; i < 33; i++) begin
        words[i] = 32'h9E37_79B9 * (i + 1) + 32'(k * 977);
        tx_wr = 1'b1; tx_wdata = words[i]; cyc(); tx_wr = 1'b0;
        if (i < 32) begin
          chk("R7 tx_req level", 32'(tx_req), 32'((DEPTH - (i + 1)) >= thr));
          chk("R5 tx count", 32'(tx_count), i + 1);
        end
      end
      chk("R5 full count", 32'(tx_count), 32);
      chk("R5 tx ovf", 32'(tx_ovf), 1);
      for (int i = 0; i < 32; i++) begin
        chk(lsb ? "R3 lsb align" : "R2 msb align", 32'(ser_data), 32'(exp_tx(lsb, words[i])));
        ser_pop = 1'b1; cyc(); ser_pop = 1'b0;
      end
      chk("R5 drained", 32'(ser_valid), 0);
      chk("R5 no udf yet", 32'(tx_udf), 0);
      ser_pop = 1'b1; cyc(); ser_pop = 1'b0;
      chk("R5 tx udf", 32'(tx_udf), 1);
      set_cfg(cword(1'b1, 1'b1, 1'b0, thr, 15, lsb, 0));
      chk("R9 tx flags cleared", {30'h0, tx_ovf, tx_udf}, 0);
    end

    // receive sweeps over packing and threshold
    for (int m = 0; m < 4; m++) begin
      thr = (m == 0) ? 0 : (m == 1) ? 7 : (m == 2) ? 15 : 31;
      set_cfg(cword(1'b1, 1'b0, 1'b0, 16, thr, 1'b0, m));
      chk("R8 rx_req empty", 32'(rx_req), 0);
      for (int i = 0; i < 33; i++) begin
        smps[i] = 24'((32'hA5C3_1F77 * (i + 3 + m * 41)) >> 5);
        des_push = 1'b1; des_data = smps[i]; cyc(); des_push = 1'b0;
        if (i < 32) chk("R8 rx_req level", 32'(rx_req), 32'((i + 1) >= thr + 1));
      end
      chk("R6 rx ovf", 32'(rx_ovf), 1);
      chk("R6 rx full", 32'(rx_count), 32);
      for (int i = 0; i < 32; i++) begin
        chk("R4 packing", rx_rdata, exp_rx(m, smps[i]));
        rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
      end
      chk("R6 no udf yet", 32'(rx_udf), 0);
      rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
      chk("R6 rx udf", 32'(rx_udf), 1);
      chk("R6 still empty", 32'(rx_empty), 1);
      set_cfg(cword(1'b1, 1'b0, 1'b1, 16, thr, 1'b0, m));
      chk("R9 rx flags cleared", {30'h0, rx_ovf, rx_udf}, 0);
    end

    // R9 flush together with a push
    for (int i = 0; i < 5; i++) begin
      tx_wr = 1'b1; tx_wdata = 32'(i * 3 + 1) << 8; cyc(); tx_wr = 1'b0;
    end
    cfg_wr = 1'b1; cfg_wdata = cword(1'b1, 1'b1, 1'b0, 16, 15, 1'b0, 0);
    tx_wr = 1'b1; tx_wdata = 32'hFFFF_FF00; cyc();
    cfg_wr = 1'b0; tx_wr = 1'b0;
    chk("R9 tx flush beats push", 32'(tx_count), 0);
    for (int i = 0; i < 32; i++) begin
      tx_wr = 1'b1; tx_wdata = 32'(i) << 8; cyc(); tx_wr = 1'b0;
    end
    cfg_wr = 1'b1; cfg_wdata = cword(1'b1, 1'b1, 1'b0, 16, 15, 1'b0, 0);
    tx_wr = 1'b1; cyc();
    cfg_wr = 1'b0; tx_wr = 1'b0;
    chk("R9 full flush count", 32'(tx_count), 0);
    chk("R9 full flush no ovf", 32'(tx_ovf), 0);
    for (int i = 0; i < 3; i++) begin
      des_push = 1'b1; des_data = 24'(i + 9); cyc(); des_push = 1'b0;
    end
    cfg_wr = 1'b1; cfg_wdata = cword(1'b1, 1'b0, 1'b1, 16, 15, 1'b0, 0);
    des_push = 1'b1; rx_rd = 1'b1; cyc();
    cfg_wr = 1'b0; des_push = 1'b0; rx_rd = 1'b0;
    chk("R9 rx flush beats push/pop", 32'(rx_count), 0);
    chk("R9 rx flush no flags", {30'h0, rx_ovf, rx_udf}, 0);
    chk("R9 flush bits read zero", 32'(cfg_rdata[17:16]), 0);
    chk("R1 field readback", cfg_rdata, 32'h8000_1078);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule